// File: doc/BRIEF.md
# Line and Rectangle Pixel Rasterizer

This block turns drawing commands from a processor into single-pixel memory writes for a frame buffer with 16 bits per pixel. Software sets up two corner or endpoint coordinates, a color and a frame-buffer base address through a small register port. It then writes a launch command. The block walks either a straight line, using integer error stepping, or a solid axis-aligned box, and offers each pixel on a valid/ready output channel.

Screen width and height are fixed by parameters. Each pixel is tested against them just before output. Pixels outside the screen are dropped but still take their cycle, so shapes may hang off any edge, including at negative coordinates. Launching a command never stalls the processor. A status read returns the busy flag at once. Any register write made while a shape is in progress is held off by the wait line until the block goes idle, so any write can serve as a fence.

Top module: `raster_engine`

## Requirements
- R1: A line command (control bit 1 = 0) emits every point of the integer error-stepping walk from (x0,y0) to (x1,y1), both endpoints included, in walk order. Either direction and any slope is accepted.
- R2: A box command (control bit 1 = 1) covers every point with x between x0 and x1 and y between y0 and y1, inclusive. Output order is x rising within a row and rows by rising y, whichever corner is given first.
- R3: Only points with 0 <= x < SCR_W and 0 <= y < SCR_H appear on the pixel channel. Coordinates are signed 16-bit values.
- R4: After a launch, the busy flag stays high for exactly 4 setup cycles, plus one cycle per generated point (on or off screen), plus one cycle for each cycle the channel holds a valid pixel with ready low.
- R5: The pixel address is base + 2*(y*SCR_W + x). The pixel data is the low 16 bits of the color register.
- R6: While pix_valid is high and pix_ready is low, the next cycle keeps pix_valid high with the same address and data.
- R7: A read never raises csr_wait. Reading register 7 returns the busy flag in bit 0 in the same cycle.
- R8: A write while busy keeps csr_wait high until busy falls, then takes effect. The color register is index 5.
- R9: Register map: 0 control (bit 0 launch, bit 1 shape), 1 x0, 2 y0, 3 x1, 4 y1, 5 color, 6 base, 7 status. A control write with bit 0 clear only stores the shape bit and launches nothing.
- R10: After reset the block is idle: status reads 0, pix_valid is low and csr_wait is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 3 | Register index |
| csr_write | input | 1 | Register write request |
| csr_wdata | input | 32 | Register write data |
| csr_read | input | 1 | Register read request |
| csr_rdata | output | 32 | Read data, valid in the cycle of csr_read |
| csr_wait | output | 1 | Holds a write off while a shape is in progress |
| pix_valid | output | 1 | A visible pixel is offered |
| pix_ready | input | 1 | Memory side accepts the pixel this cycle |
| pix_addr | output | ADDR_W | Byte address of the pixel |
| pix_data | output | 16 | Pixel color |

The pixel channel follows valid/ready rules. A pixel transfers on a clock edge where both pix_valid and pix_ready are high. Once pix_valid is raised, it stays up with unchanged address and data until the transfer happens.

## Verification
Lines are tried in every octant: flat, steep, reversed, single-point and long random ones. Their output sequence separates a correct error walk from one that misorders the two axis steps or drops an endpoint. Boxes are given with corners in reversed order and straddling each screen edge, which tests corner normalization and row-major order. Shapes partly or wholly off screen, including negative coordinates, tell clipping at the output apart from clipping that would shorten the walk, because the busy length must still count every point. Random ready back-pressure, a change of base address and a color write made during a draw expose any pixel that advances, changes or is lost under stall, and any write that slips past the wait.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int CSR_AW    = 3;
  localparam int CSR_DW    = 32;
  localparam int NUM_COORD = 4;

  localparam logic [CSR_AW-1:0] REG_CTRL   = 3'd0;
  localparam logic [CSR_AW-1:0] REG_X0     = 3'd1;
  localparam logic [CSR_AW-1:0] REG_COLOR  = 3'd5;
  localparam logic [CSR_AW-1:0] REG_BASE   = 3'd6;
  localparam logic [CSR_AW-1:0] REG_STATUS = 3'd7;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_KIND_BIT = 1;
  localparam int STAT_BUSY_BIT = 0;

  typedef enum logic {KIND_LINE = 1'b0, KIND_BOX = 1'b1} shape_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_DRAW} walk_state_e;
endpackage

// File: rtl/raster_csr.sv
module raster_csr
  import raster_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PIX_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [CSR_AW-1:0]                   csr_addr,
  input  logic                                csr_write,
  input  logic [CSR_DW-1:0]                   csr_wdata,
  input  logic                                csr_read,
  output logic [CSR_DW-1:0]                   csr_rdata,
  output logic                                csr_wait,
  input  logic                                busy,
  output logic                                launch,
  output shape_kind_e                         kind,
  output logic [NUM_COORD-1:0][CSR_DW-1:0]    coord,
  output logic [PIX_W-1:0]                    color,
  output logic [ADDR_W-1:0]                   base
);
  logic commit;

  // writes are held off for the whole primitive; reads are never held
  assign csr_wait = csr_write && busy;
  assign commit   = csr_write && !busy;
  assign launch   = commit && (csr_addr == REG_CTRL) && csr_wdata[CTRL_GO_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind  <= KIND_LINE;
      color <= '0;
      base  <= '0;
    end else if (commit) begin
      if (csr_addr == REG_CTRL)  kind  <= shape_kind_e'(csr_wdata[CTRL_KIND_BIT]);
      if (csr_addr == REG_COLOR) color <= csr_wdata[PIX_W-1:0];
      if (csr_addr == REG_BASE)  base  <= ADDR_W'(csr_wdata);
    end
  end

  for (genvar gi = 0; gi < NUM_COORD; gi++) begin : g_coord
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        coord[gi] <= '0;
      end else if (commit && (csr_addr == REG_X0 + CSR_AW'(gi))) begin
        coord[gi] <= csr_wdata;
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_read) begin
      case (csr_addr)
        REG_CTRL:   csr_rdata[CTRL_KIND_BIT] = kind;
        REG_COLOR:  csr_rdata = CSR_DW'(color);
        REG_BASE:   csr_rdata = CSR_DW'(base);
        REG_STATUS: csr_rdata[STAT_BUSY_BIT] = busy;
        default: begin
          for (int i = 0; i < NUM_COORD; i++) begin
            if (csr_addr == REG_X0 + CSR_AW'(i)) csr_rdata = coord[i];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/raster_walker.sv
module raster_walker
  import raster_pkg::*;
#(
  parameter int CW        = 16,
  parameter int SETUP_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  shape_kind_e          kind,
  input  logic signed [CW-1:0] x0,
  input  logic signed [CW-1:0] y0,
  input  logic signed [CW-1:0] x1,
  input  logic signed [CW-1:0] y1,
  input  logic                 adv,
  output logic                 busy,
  output logic                 live,
  output logic signed [CW-1:0] cur_x,
  output logic signed [CW-1:0] cur_y
);
  localparam int EW   = CW + 3;
  localparam int SC_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETUP_CYC - 1);
  localparam logic signed [CW-1:0] C_UP   = CW'(1);
  localparam logic signed [CW-1:0] C_DOWN = '1;

  walk_state_e           state;
  logic [SC_W-1:0]       setup_cnt;
  logic                  is_box;
  logic signed [CW-1:0]  end_x, end_y, row_x;
  logic signed [EW-1:0]  dx, dy, err;
  logic                  neg_x, neg_y;

  // setup arithmetic on the (stable) coordinate registers
  logic signed [EW-1:0] ex0, ey0, ex1, ey1, ddx, ddy, adx, ady;
  logic signed [CW-1:0] lo_x, hi_x, lo_y, hi_y;
  always_comb begin
    ex0  = $signed({{(EW-CW){x0[CW-1]}}, x0});
    ey0  = $signed({{(EW-CW){y0[CW-1]}}, y0});
    ex1  = $signed({{(EW-CW){x1[CW-1]}}, x1});
    ey1  = $signed({{(EW-CW){y1[CW-1]}}, y1});
    ddx  = ex1 - ex0;
    ddy  = ey1 - ey0;
    adx  = ddx[EW-1] ? -ddx : ddx;
    ady  = ddy[EW-1] ? -ddy : ddy;
    lo_x = (x0 < x1) ? x0 : x1;
    hi_x = (x0 < x1) ? x1 : x0;
    lo_y = (y0 < y1) ? y0 : y1;
    hi_y = (y0 < y1) ? y1 : y0;
  end

  // one step of the walk
  logic signed [EW-1:0] e2, nerr;
  logic                 go_x, go_y, at_end, row_end;
  always_comb begin
    e2      = err <<< 1;
    go_x    = (e2 >= dy);
    go_y    = (e2 <= dx);
    nerr    = err + (go_x ? dy : '0) + (go_y ? dx : '0);
    at_end  = (cur_x == end_x) && (cur_y == end_y);
    row_end = (cur_x == end_x);
  end

  assign busy = (state != ST_IDLE);
  assign live = (state == ST_DRAW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      setup_cnt <= '0;
      is_box    <= 1'b0;
      cur_x     <= '0;
      cur_y     <= '0;
      end_x     <= '0;
      end_y     <= '0;
      row_x     <= '0;
      dx        <= '0;
      dy        <= '0;
      err       <= '0;
      neg_x     <= 1'b0;
      neg_y     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launch) begin
            state     <= ST_SETUP;
            setup_cnt <= SC_LAST;
          end
        end
        ST_SETUP: begin
          if (setup_cnt != '0) begin
            setup_cnt <= setup_cnt - SC_W'(1);
          end else begin
            state  <= ST_DRAW;
            is_box <= (kind == KIND_BOX);
            if (kind == KIND_BOX) begin
              cur_x <= lo_x;
              cur_y <= lo_y;
              row_x <= lo_x;
              end_x <= hi_x;
              end_y <= hi_y;
            end else begin
              cur_x <= x0;
              cur_y <= y0;
              end_x <= x1;
              end_y <= y1;
              dx    <= adx;
              dy    <= -ady;
              err   <= adx - ady;
              neg_x <= ddx[EW-1];
              neg_y <= ddy[EW-1];
            end
          end
        end
        ST_DRAW: begin
          if (adv) begin
            if (at_end) begin
              state <= ST_IDLE;
            end else if (is_box) begin
              if (row_end) begin
                cur_x <= row_x;
                cur_y <= cur_y + C_UP;
              end else begin
                cur_x <= cur_x + C_UP;
              end
            end else begin
              err <= nerr;
              if (go_x) cur_x <= cur_x + (neg_x ? C_DOWN : C_UP);
              if (go_y) cur_y <= cur_y + (neg_y ? C_DOWN : C_UP);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/raster_emit.sv
module raster_emit #(
  parameter int CW     = 16,
  parameter int SCR_W  = 640,
  parameter int SCR_H  = 480,
  parameter int ADDR_W = 32,
  parameter int PIX_W  = 16
) (
  input  logic                 live,
  input  logic signed [CW-1:0] cur_x,
  input  logic signed [CW-1:0] cur_y,
  input  logic [ADDR_W-1:0]    base,
  input  logic [PIX_W-1:0]     color,
  input  logic                 pix_ready,
  output logic                 pix_valid,
  output logic [ADDR_W-1:0]    pix_addr,
  output logic [PIX_W-1:0]     pix_data,
  output logic                 adv
);
  localparam int BYTE_SH = $clog2(PIX_W / 8);

  logic on_x, on_y, on_screen;
  logic [ADDR_W-1:0] row_off, lin;

  assign on_x      = !cur_x[CW-1] && ($unsigned(cur_x) < CW'(SCR_W));
  assign on_y      = !cur_y[CW-1] && ($unsigned(cur_y) < CW'(SCR_H));
  assign on_screen = on_x && on_y;

  if ((SCR_W & (SCR_W - 1)) == 0) begin : g_row_shift
    assign row_off = ADDR_W'($unsigned(cur_y)) << $clog2(SCR_W);
  end else begin : g_row_mul
    assign row_off = ADDR_W'($unsigned(cur_y)) * ADDR_W'(SCR_W);
  end

  assign lin       = row_off + ADDR_W'($unsigned(cur_x));
  assign pix_addr  = base + (lin << BYTE_SH);
  assign pix_data  = color;
  assign pix_valid = live && on_screen;
  // off-screen points still consume their cycle; visible ones wait for ready
  assign adv       = live && (!on_screen || pix_ready);
endmodule

// File: rtl/raster_engine.sv
module raster_engine
  import raster_pkg::*;
#(
  parameter int SCR_W     = 640,
  parameter int SCR_H     = 480,
  parameter int ADDR_W    = 32,
  parameter int CW        = 16,
  parameter int SETUP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        csr_addr,
  input  logic              csr_write,
  input  logic [31:0]       csr_wdata,
  input  logic              csr_read,
  output logic [31:0]       csr_rdata,
  output logic              csr_wait,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [ADDR_W-1:0] pix_addr,
  output logic [15:0]       pix_data
);
  localparam int PIX_W = 16;

  logic                              busy, launch, live, adv;
  shape_kind_e                       kind;
  logic [NUM_COORD-1:0][CSR_DW-1:0]  coord_q;
  logic [PIX_W-1:0]                  color_q;
  logic [ADDR_W-1:0]                 base_q;
  logic signed [CW-1:0]              cur_x, cur_y;

  raster_csr #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_addr  (csr_addr),
    .csr_write (csr_write),
    .csr_wdata (csr_wdata),
    .csr_read  (csr_read),
    .csr_rdata (csr_rdata),
    .csr_wait  (csr_wait),
    .busy      (busy),
    .launch    (launch),
    .kind      (kind),
    .coord     (coord_q),
    .color     (color_q),
    .base      (base_q)
  );

  raster_walker #(.CW(CW), .SETUP_CYC(SETUP_CYC)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .kind   (kind),
    .x0     (coord_q[0][CW-1:0]),
    .y0     (coord_q[1][CW-1:0]),
    .x1     (coord_q[2][CW-1:0]),
    .y1     (coord_q[3][CW-1:0]),
    .adv    (adv),
    .busy   (busy),
    .live   (live),
    .cur_x  (cur_x),
    .cur_y  (cur_y)
  );

  raster_emit #(
    .CW(CW), .SCR_W(SCR_W), .SCR_H(SCR_H), .ADDR_W(ADDR_W), .PIX_W(PIX_W)
  ) u_emit (
    .live      (live),
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .base      (base_q),
    .color     (color_q),
    .pix_ready (pix_ready),
    .pix_valid (pix_valid),
    .pix_addr  (pix_addr),
    .pix_data  (pix_data),
    .adv       (adv)
  );
endmodule

// File: rtl/raster_engine_chk.sv
module raster_engine_chk #(
  parameter int SCR_W  = 640,
  parameter int SCR_H  = 480,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_read,
  input logic              csr_write,
  input logic              csr_wait,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [ADDR_W-1:0] pix_addr,
  input logic [15:0]       pix_data,
  input logic              busy,
  input logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * SCR_W * SCR_H);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_addr) && $stable(pix_data));

  p_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ((pix_addr - base) < SPAN) && !pix_addr[0]);

  p_read_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_read && !csr_write |-> !csr_wait);

  p_wait_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wait |-> busy);

  p_setup_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !pix_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pix_valid);
endmodule

bind raster_engine raster_engine_chk #(
  .SCR_W(SCR_W), .SCR_H(SCR_H), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_read  (csr_read),
  .csr_write (csr_write),
  .csr_wait  (csr_wait),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_addr  (pix_addr),
  .pix_data  (pix_data),
  .busy      (busy),
  .base      (base_q)
);

// File: tb/tb_raster_engine.sv
module tb_raster_engine;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 640;
  localparam int H = 480;
  localparam int SETUP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic        csr_write = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic        csr_read = 1'b0;
  logic [31:0] csr_rdata;
  logic        csr_wait;
  logic        pix_valid;
  logic        pix_ready = 1'b1;
  logic [31:0] pix_addr;
  logic [15:0] pix_data;

  int checks = 0;
  int errors = 0;
  int px[$];
  int py[$];

  always #2.5 clk = ~clk;

  raster_engine dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_write(csr_write),
    .csr_wdata(csr_wdata), .csr_read(csr_read), .csr_rdata(csr_rdata),
    .csr_wait(csr_wait), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_addr(pix_addr), .pix_data(pix_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  // expected walk, all points including off-screen ones
  function automatic void gen(input bit box, input int x0, input int y0,
                              input int x1, input int y1);
    px.delete(); py.delete();
    if (box) begin
      int lx = (x0 < x1) ? x0 : x1;
      int hx = (x0 < x1) ? x1 : x0;
      int ly = (y0 < y1) ? y0 : y1;
      int hy = (y0 < y1) ? y1 : y0;
      for (int y = ly; y <= hy; y++)
        for (int x = lx; x <= hx; x++) begin px.push_back(x); py.push_back(y); end
    end else begin
      int dx = (x1 > x0) ? x1 - x0 : x0 - x1;
      int dy = (y1 > y0) ? y0 - y1 : y1 - y0;
      int sx = (x1 < x0) ? -1 : 1;
      int sy = (y1 < y0) ? -1 : 1;
      int err = dx + dy;
      int x = x0;
      int y = y0;
      forever begin
        int e2;
        px.push_back(x); py.push_back(y);
        if (x == x1 && y == y1) break;
        e2 = 2 * err;
        if (e2 >= dy) begin err += dy; x += sx; end
        if (e2 <= dx) begin err += dx; y += sy; end
      end
    end
  endfunction

  task automatic csr_wr(input int a, input int d, output int waits);
    waits = 0;
    @(negedge clk);
    csr_addr = 3'(a); csr_write = 1'b1; csr_wdata = 32'(d); csr_read = 1'b0;
    #1;
    while (csr_wait) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    csr_write = 1'b0;
  endtask

  task automatic csr_rd(input int a, output logic [31:0] d, output logic w);
    @(negedge clk);
    csr_addr = 3'(a); csr_read = 1'b1; csr_write = 1'b0;
    #1;
    d = csr_rdata; w = csr_wait;
    @(negedge clk);
    csr_read = 1'b0;
  endtask

  task automatic run_prim(input bit box, input int x0, input int y0, input int x1,
                          input int y1, input int color, input int base,
                          input int rdy_pct, input string tag);
    int w, busy_cnt, stalls, idx, bad_at, hold_bad, rd_wait;
    logic [31:0] ea[$];
    logic [31:0] prev_a, bad_act, bad_exp;
    logic [15:0] prev_d;
    bit prev_stall;
    csr_wr(6, base, w);
    csr_wr(5, color, w);
    csr_wr(1, x0, w); csr_wr(2, y0, w); csr_wr(3, x1, w); csr_wr(4, y1, w);
    gen(box, x0, y0, x1, y1);
    for (int i = 0; i < px.size(); i++)
      if (px[i] >= 0 && px[i] < W && py[i] >= 0 && py[i] < H)
        ea.push_back(32'(base + 2 * (py[i] * W + px[i])));
    csr_wr(0, (int'(box) << 1) | 1, w);
    busy_cnt = 0; stalls = 0; idx = 0; bad_at = -1; hold_bad = 0; rd_wait = 0;
    prev_stall = 0; prev_a = '0; prev_d = '0; bad_act = '0; bad_exp = '0;
    forever begin
      csr_read = 1'b1; csr_addr = 3'd7;
      pix_ready = (rnd(0, 99) < rdy_pct);
      #1;
      if (csr_wait) rd_wait++;
      if (!csr_rdata[0]) break;
      busy_cnt++;
      if (prev_stall && !(pix_valid && pix_addr == prev_a && pix_data == prev_d)) hold_bad++;
      prev_stall = 1'b0;
      if (pix_valid) begin
        if (bad_at < 0) begin
          if (idx >= ea.size()) begin
            bad_at = idx; bad_act = pix_addr; bad_exp = '1;
          end else if (pix_addr != ea[idx] || pix_data != 16'(color)) begin
            bad_at = idx; bad_act = pix_addr; bad_exp = ea[idx];
          end
        end
        if (pix_ready) idx++;
        else begin stalls++; prev_stall = 1'b1; prev_a = pix_addr; prev_d = pix_data; end
      end
      @(negedge clk);
    end
    csr_read = 1'b0; pix_ready = 1'b1;
    // pixel sequence: walk order, clipping (R3), address and data (R5)
    check(bad_at < 0, tag, $sformatf("pixel %0d address (R3/R5)", bad_at), bad_act, bad_exp);
    check(idx == ea.size(), tag, "visible pixel count (R3)", idx, ea.size());
    // every point costs a cycle, clipped or not (R4)
    check(busy_cnt == SETUP + px.size() + stalls, "R4", "busy cycles", busy_cnt,
          SETUP + px.size() + stalls);
    check(rd_wait == 0, "R7", "status read wait cycles", rd_wait, 0);
    if (stalls > 0) check(hold_bad == 0, "R6", "stalled pixel not held", hold_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic wt;
    int w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    csr_rd(7, d, wt);
    check(d == 0, "R10", "status after reset", d, 0);
    check(!pix_valid && !csr_wait, "R10", "valid/wait after reset", {pix_valid, csr_wait}, 0);
    check(!wt, "R7", "wait during read", wt, 0);

    // directed lines R1
    run_prim(0, 10, 20, 30, 20, 16'hF800, 32'h1000_0000, 100, "R1");
    run_prim(0, 100, 200, 90, 150, 16'h07E0, 32'h1000_0000, 100, "R1");
    run_prim(0, 5, 5, 5, 5, 16'h001F, 32'h1000_0000, 100, "R1");
    run_prim(0, 300, 10, 0, 40, 16'h1234, 32'h2000_0000, 100, "R1");
    // directed boxes R2
    run_prim(1, 50, 60, 40, 55, 16'hABCD, 32'h1000_0000, 100, "R2");
    run_prim(1, 630, 470, 645, 485, 16'h5555, 32'h1000_0000, 100, "R2");
    // clipping R3/R4: partly and wholly off screen
    run_prim(0, -10, -5, 20, 30, 16'h0F0F, 32'h1000_0000, 100, "R3");
    run_prim(1, -50, 10, -40, 14, 16'h7777, 32'h1000_0000, 100, "R4");
    // back-pressure R6 and a new base R5
    run_prim(0, 0, 0, 200, 60, 16'hCAFE, 32'h0004_0000, 40, "R6");
    run_prim(1, 3, 4, 12, 9, 16'hBEEF, 32'h0123_4560, 50, "R5");

    // R8: color write during a 10-point line waits until idle
    csr_wr(1, 0, w); csr_wr(2, 0, w); csr_wr(3, 9, w); csr_wr(4, 0, w);
    csr_wr(0, 1, w);
    pix_ready = 1'b1;
    csr_wr(5, 16'h4321, w);
    // first wait sample is one cycle after launch: 4 + 10 - 1
    check(w == SETUP + 10 - 1, "R8", "write wait cycles", w, SETUP + 10 - 1);
    csr_rd(5, d, wt);
    check(d == 32'h4321, "R8", "color after held write", d, 32'h4321);

    // R9: control write without launch bit
    csr_wr(0, 2, w);
    csr_rd(7, d, wt);
    check(d == 0, "R9", "status after non-launch write", d, 0);
    check(!pix_valid, "R9", "no pixel after non-launch write", pix_valid, 0);
    csr_rd(0, d, wt);
    check(d == 2, "R9", "shape bit readback", d, 2);

    // random mix
    for (int n = 0; n < 40; n++) begin
      bit box = rnd(0, 1) == 1;
      int xa, ya, xb, yb;
      if (box) begin
        xa = rnd(-30, W + 10); ya = rnd(-30, H + 10);
        xb = xa + rnd(-20, 20); yb = ya + rnd(-12, 12);
      end else begin
        xa = rnd(-60, W + 60); ya = rnd(-60, H + 60);
        xb = rnd(-60, W + 60); yb = rnd(-60, H + 60);
      end
      run_prim(box, xa, ya, xb, yb, rnd(0, 65535), rnd(0, 1023) * 4096, rnd(30, 100),
               box ? "R2" : "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule